// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

This block gathers 28 interrupt pins from peripherals and presents them to a processor as one level-sensitive interrupt line. The pins fall into four byte-wide groups. Each pin first passes through a two-flop synchroniser. It is then compared against a fixed idle level, so active-high and active-low sources can share a group. A per-source enable mask at the second level gates each active source.

Surviving sources are folded by a fixed, irregular routing function onto twelve first-level request lines. A first-level mask gates those lines, and the OR of the remaining lines drives the processor interrupt.

Software uses a small byte-wide register bus with combinational reads and clocked writes. Through it, software can:
- read the synchronised pin levels;
- program both mask layers;
- read a vector byte naming the lowest-numbered pending source.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every implemented mask bit is 1: offsets 4, 5, 6 and 8 read 0xFF, offsets 7 and 9 read 0x0F, offset 10 reads 0x00, and `cpu_irq` is low.
- R2: Offsets 0 to 3 return the synchronised levels of pins 8g+7..8g for group g; bits 7:4 of offset 3 read zero. A pin change is visible after two rising clock edges.
- R3: Source n is active when its pin differs from bit n of the idle pattern. The idle byte is 0x00 for group 0, 0xBE for group 1, 0xFC for group 2 and 0xF7 for group 3.
- R4: Offsets 4 to 7 hold the second-level masks for groups 0 to 3, bit b for source 8g+b. A 1 blocks that source from both the line request and the vector.
- R5: The routing of sources to lines is fixed:
  - sources 0..7 route to line 7; 9..13 to line 6; 18..21 to line 5;
  - 8 routes to line 4; 14 to line 8; 15 to line 9; 22 to line 0; 23 to line 1; 24 to line 3; 27 to line 2;
  - 16..17 route to line 11; 25..26 to line 10.
- R6: Offset 8 bit k masks line k for k = 0..7, and offset 9 bit k-8 masks line k for k = 8..11. A 1 blocks the line.
- R7: `cpu_irq` is high exactly while some active source is unmasked at the second level and its line is unmasked at the first level. It holds as long as that condition holds.
- R8: Offset 10 reads 0x80 + n, where n is the lowest-numbered active, second-level-unmasked source, across all groups. It reads 0x00 when no such source exists. First-level masks do not affect it.
- R9: Writes to offsets 0 to 3 and 10 to 15 change no state. Offsets 11 to 15 read 0x00, and unimplemented mask bits read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | 28 | Asynchronous interrupt pins, source n on bit n |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | Level interrupt request to the processor |

## Verification
The main function is exercised with several pin patterns:
- **All pins at the idle pattern.** This tells a correct polarity table apart from a plain active-high reading, since the interrupt must stay quiet and the vector read zero.
- **Each source toggled on its own.** The first level is opened only on the predicted line, then closed only on that line. This separates a correct routing entry from any misrouted one.
- **Two sources in different groups at once.** This distinguishes lowest-number priority from per-group or highest-first selection.
- **A second-level mask on the winner.** The vector must fall to the next source.

Writes to read-only offsets and to unimplemented mask bits are read back to confirm they had no effect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int GRP_W     = 8;
    localparam int N_GRP     = 4;
    localparam int N_SRC     = 28;
    localparam int N_LINE    = 12;
    localparam int ADDR_W    = 4;
    localparam int NO_LINE   = 255;

    // Per-source idle level, group 3 in the top byte.
    localparam logic [N_GRP*GRP_W-1:0] IDLE_PATTERN = 32'hF7FC_BE00;

    // Fixed routing of a second-level source onto a first-level line.
    function automatic int src_line(input int n);
        int l;
        if (n <= 7)                  l = 7;
        else if (n == 8)             l = 4;
        else if (n <= 13)            l = 6;
        else if (n == 14)            l = 8;
        else if (n == 15)            l = 9;
        else if (n <= 17)            l = 11;
        else if (n <= 21)            l = 5;
        else if (n == 22)            l = 0;
        else if (n == 23)            l = 1;
        else if (n == 24)            l = 3;
        else if (n <= 26)            l = 10;
        else if (n == 27)            l = 2;
        else                         l = NO_LINE;
        return l;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/irq_agg_route.sv
module irq_agg_route
    import irq_agg_pkg::*;
#(
    parameter int                          NSRC   = N_SRC,
    parameter int                          NLINE  = N_LINE,
    parameter int                          VEC_W  = $clog2(NSRC),
    parameter logic [NSRC-1:0]             IDLE   = IDLE_PATTERN[NSRC-1:0]
) (
    input  logic [NSRC-1:0]  pins_sync,
    input  logic [NSRC-1:0]  l2_mask,
    input  logic [NLINE-1:0] l1_mask,
    output logic             cpu_irq,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_num
);
    logic [NSRC-1:0]  live;
    logic [NLINE-1:0] line_req;

    always_comb begin
        live = (pins_sync ^ IDLE) & ~l2_mask;
    end

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        always_comb begin
            line_req[k] = 1'b0;
            for (int n = 0; n < NSRC; n++) begin
                if (src_line(n) == k) line_req[k] = line_req[k] | live[n];
            end
        end
    end

    always_comb begin
        cpu_irq = |(line_req & ~l1_mask);
    end

    // Lowest-numbered live source wins.
    always_comb begin
        vec_valid = 1'b0;
        vec_num   = '0;
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (live[n]) begin
                vec_valid = 1'b1;
                vec_num   = VEC_W'(n);
            end
        end
    end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NSRC   = N_SRC,
    parameter int NLINE  = N_LINE,
    parameter int NGRP   = N_GRP,
    parameter int AW     = ADDR_W,
    parameter int VEC_W  = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [NSRC-1:0]  pins_sync,
    input  logic             vec_valid,
    input  logic [VEC_W-1:0] vec_num,
    output logic [NSRC-1:0]  l2_mask,
    output logic [NLINE-1:0] l1_mask
);
    localparam int L2_BITS  = NGRP * 8;
    localparam int L1_REGS  = (NLINE + 7) / 8;
    localparam int L1_BITS  = L1_REGS * 8;
    localparam int OFF_L2   = NGRP;
    localparam int OFF_L1   = OFF_L2 + NGRP;
    localparam int OFF_VEC  = OFF_L1 + L1_REGS;
    localparam logic [L2_BITS-1:0] SRC_VALID  = L2_BITS'((64'd1 << NSRC) - 64'd1);
    localparam logic [L1_BITS-1:0] LINE_VALID = L1_BITS'((64'd1 << NLINE) - 64'd1);

    logic [L2_BITS-1:0] l2_q;
    logic [L1_BITS-1:0] l1_q;
    logic [L2_BITS-1:0] stat_word;
    int                 idx;
    logic               ro_hit;

    always_comb begin
        idx       = int'(bus_addr);
        stat_word = L2_BITS'(pins_sync);
        ro_hit    = (idx < OFF_L2) || (idx >= OFF_VEC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l2_q <= SRC_VALID;
            l1_q <= LINE_VALID;
        end else if (bus_wr) begin
            if (idx >= OFF_L2 && idx < OFF_L1)
                l2_q[8*(idx-OFF_L2) +: 8] <= bus_wdata & SRC_VALID[8*(idx-OFF_L2) +: 8];
            else if (idx >= OFF_L1 && idx < OFF_VEC)
                l1_q[8*(idx-OFF_L1) +: 8] <= bus_wdata & LINE_VALID[8*(idx-OFF_L1) +: 8];
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (idx < OFF_L2)
            bus_rdata = stat_word[8*idx +: 8];
        else if (idx < OFF_L1)
            bus_rdata = l2_q[8*(idx-OFF_L2) +: 8];
        else if (idx < OFF_VEC)
            bus_rdata = l1_q[8*(idx-OFF_L1) +: 8];
        else if (idx == OFF_VEC)
            bus_rdata = {vec_valid, 7'(vec_num)};
    end

    assign l2_mask = l2_q[NSRC-1:0];
    assign l1_mask = l1_q[NLINE-1:0];

    // R1: masks hold their reset pattern the cycle after reset is seen
    assert_reset_masks_R1: assert property (@(posedge clk)
        !rst_n |=> (l2_q == SRC_VALID && l1_q == LINE_VALID));

    // R9: a write to a read-only offset leaves all mask state unchanged
    assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ro_hit) |=> ($stable(l2_q) && $stable(l1_q)));

    // R6: a write to the low first-level mask register lands next cycle
    assert_l1_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == OFF_L1) |=> (l1_q[7:0] == $past(bus_wdata)));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int NLINE = N_LINE,
    parameter int NGRP  = N_GRP,
    parameter int AW    = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_pins,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic            cpu_irq
);
    localparam int VEC_W   = $clog2(NSRC);
    localparam int OFF_VEC = 2 * NGRP + (NLINE + 7) / 8;

    logic [NSRC-1:0]  pins_sync;
    logic [NSRC-1:0]  l2_mask;
    logic [NLINE-1:0] l1_mask;
    logic             vec_valid;
    logic [VEC_W-1:0] vec_num;

    irq_agg_sync #(.W(NSRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_pins),
        .q_sync  (pins_sync)
    );

    irq_agg_route #(
        .NSRC  (NSRC),
        .NLINE (NLINE),
        .VEC_W (VEC_W),
        .IDLE  (IDLE_PATTERN[NSRC-1:0])
    ) u_route (
        .pins_sync (pins_sync),
        .l2_mask   (l2_mask),
        .l1_mask   (l1_mask),
        .cpu_irq   (cpu_irq),
        .vec_valid (vec_valid),
        .vec_num   (vec_num)
    );

    irq_agg_regs #(
        .NSRC  (NSRC),
        .NLINE (NLINE),
        .NGRP  (NGRP),
        .AW    (AW),
        .VEC_W (VEC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_sync (pins_sync),
        .vec_valid (vec_valid),
        .vec_num   (vec_num),
        .l2_mask   (l2_mask),
        .l1_mask   (l1_mask)
    );

    // R6: with every line blocked the processor interrupt stays low
    assert_l1_all_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_mask == '1) |-> !cpu_irq);

    // R8: a valid vector always names an implemented source
    assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) == OFF_VEC && bus_rdata[7]) |-> (int'(bus_rdata[6:0]) < NSRC));

    // R7: an interrupt requires some synchronised pin away from its idle level
    assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (pins_sync != IDLE_PATTERN[NSRC-1:0]));
endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;

    typedef struct {
        int        kind;   // 0: read bus_rdata, 1: sample cpu_irq
        logic [7:0] exp;
        string     req;
    } sb_item_t;

    localparam logic [27:0] IDLE = 28'h7FC_BE00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] irq_pins = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cpu_irq;

    int       checks = 0;
    int       errors = 0;
    bit       done = 1'b0;
    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    irq_agg_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pins  (irq_pins),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    function automatic int line_of(input int n);
        case (n)
            0, 1, 2, 3, 4, 5, 6, 7: return 7;
            8:                      return 4;
            9, 10, 11, 12, 13:      return 6;
            14:                     return 8;
            15:                     return 9;
            16, 17:                 return 11;
            18, 19, 20, 21:         return 5;
            22:                     return 0;
            23:                     return 1;
            24:                     return 3;
            25, 26:                 return 10;
            27:                     return 2;
            default:                return -1;
        endcase
    endfunction

    // Monitor: pops expected items and compares at the falling edge.
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            sb_item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = (it.kind == 0) ? bus_rdata : {7'b0, cpu_irq};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got %02h expected %02h", it.req, got, it.exp);
            end
        end
    end

    task automatic chk_rd(input logic [3:0] a, input logic [7:0] e, input string r);
        @(posedge clk); #1;
        bus_addr = a;
        sb.push_back('{0, e, r});
    endtask

    task automatic chk_irq(input logic e, input string r);
        @(posedge clk); #1;
        sb.push_back('{1, {7'b0, e}, r});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic set_pins(input logic [27:0] v);
        @(posedge clk); #1;
        irq_pins = v;
        repeat (2) @(posedge clk);
    endtask

    task automatic set_l1(input logic [11:0] m);
        wr(4'd8, m[7:0]);
        wr(4'd9, {4'b0, m[11:8]});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        chk_rd(4'd4, 8'hFF, "R1 l2 mask g0");
        chk_rd(4'd5, 8'hFF, "R1 l2 mask g1");
        chk_rd(4'd6, 8'hFF, "R1 l2 mask g2");
        chk_rd(4'd7, 8'h0F, "R1 l2 mask g3");
        chk_rd(4'd8, 8'hFF, "R1 l1 mask lo");
        chk_rd(4'd9, 8'h0F, "R1 l1 mask hi");
        chk_rd(4'd10, 8'h00, "R1 vector");
        chk_irq(1'b0, "R1 cpu_irq");

        // R2: raw status, two-edge latency
        @(posedge clk); #1 irq_pins = IDLE;
        @(posedge clk); #1;
        sb.push_back('{0, 8'h00, "R2 status g1 one edge"});
        bus_addr = 4'd1;
        @(posedge clk);
        chk_rd(4'd1, 8'hBE, "R2 status g1");
        chk_rd(4'd0, 8'h00, "R2 status g0");
        chk_rd(4'd2, 8'hFC, "R2 status g2");
        chk_rd(4'd3, 8'h07, "R2 status g3");

        // R3: everything unmasked, all pins idle
        for (int a = 4; a < 8; a++) wr(4'(a), 8'h00);
        set_l1(12'h000);
        chk_irq(1'b0, "R3 idle pins quiet");
        chk_rd(4'd10, 8'h00, "R3 idle vector");

        // R8: cross-group lowest-number priority
        set_pins(IDLE ^ (28'd1 << 9));
        chk_rd(4'd10, 8'h89, "R8 single source 9");
        chk_irq(1'b1, "R7 irq from source 9");
        set_pins(IDLE ^ (28'd1 << 9) ^ (28'd1 << 3));
        chk_rd(4'd10, 8'h83, "R8 lowest wins");

        // R4: mask winner, vector falls to next
        wr(4'd4, 8'h08);
        chk_rd(4'd10, 8'h89, "R4 masked source 3");
        wr(4'd5, 8'h02);
        chk_rd(4'd10, 8'h00, "R4 both masked");
        chk_irq(1'b0, "R4 irq gone");
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h00);

        // R8: first-level masks do not affect vector
        set_l1(12'hFFF);
        chk_irq(1'b0, "R6 all lines masked");
        chk_rd(4'd10, 8'h83, "R8 vector ignores l1");

        // R5/R6: routing sweep
        for (int n = 0; n < 28; n++) begin
            int l;
            l = line_of(n);
            set_pins(IDLE ^ (28'd1 << n));
            set_l1(~(12'd1 << l));
            chk_irq(1'b1, $sformatf("R5 source %0d on line %0d", n, l));
            chk_rd(4'd10, 8'h80 | 8'(n), $sformatf("R8 vector source %0d", n));
            set_l1(12'd1 << l);
            chk_irq(1'b0, $sformatf("R6 line %0d masked for source %0d", l, n));
        end

        // R7: level holds, then drops when the pin returns idle
        set_l1(12'h000);
        set_pins(IDLE ^ (28'd1 << 20));
        repeat (5) @(posedge clk);
        chk_irq(1'b1, "R7 level held");
        set_pins(IDLE);
        chk_irq(1'b0, "R7 drops on removal");

        // R9: read-only and unimplemented writes
        wr(4'd0, 8'h5A);
        chk_rd(4'd0, 8'h00, "R9 status write ignored");
        wr(4'd10, 8'hFF);
        chk_rd(4'd10, 8'h00, "R9 vector write ignored");
        wr(4'd12, 8'hFF);
        chk_rd(4'd12, 8'h00, "R9 unmapped offset");
        chk_rd(4'd9, 8'h00, "R9 l1 hi unchanged");
        wr(4'd9, 8'hFF);
        chk_rd(4'd9, 8'h0F, "R9 l1 hi unused bits");
        wr(4'd7, 8'hFF);
        chk_rd(4'd7, 8'h0F, "R9 l2 g3 unused bits");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule